// File: doc/BRIEF.md
# Receive FIFO Flow-Control Hysteresis

This block tells the remote transmitter when to pause and when to carry on, based on how many characters wait in the local receive FIFO. A single byte-wide threshold register holds two 4-bit levels, each counted in steps of 8 bytes. The upper nibble is the level at which sending resumes, and the lower nibble is the level at which sending is stopped. The register accepts a write only while two separate enable bits are both set.

The block compares the FIFO fill count with both levels and keeps a two-state hysteresis (running or halted). In hardware mode this state drives an active-low request-to-send pin. In software mode each state change produces a one-cycle request for the character sender to emit XOFF (on halting) or XON (on resuming). If neither mode is enabled, the block is held in the running state and the request-to-send pin follows a software bit.

The block does not check that the two levels are ordered. Software must program the stop level above the resume level before it enables flow control. All interfaces are plain control and status pins and carry no stream handshake.

Top module: `rx_flow_hyst`

## Requirements
- R1: A write with `cfg_wr`=1 while both `feat_en` and `mctl_en` are 1 stores `cfg_wdata`, and `cfg_q` shows it from the next cycle on. Bits 3:0 are the stop level and bits 7:4 the resume level, each meaning level×8 bytes.
- R2: A write while `feat_en` or `mctl_en` is 0 is discarded, and `cfg_q` keeps its old value.
- R3: After reset `cfg_q` is 0, the state is running, and `xoff_req` and `xon_req` are 0.
- R4: While running with either mode enabled, a fill count of at least stop×8 puts the block in the halted state at the next clock edge. With `hw_fc_en`=1, `rts_n` is then 1.
- R5: When the halted state is entered while `sw_fc_en`=1, `xoff_req` is 1 for exactly one cycle.
- R6: While halted, a fill count of at most resume×8 returns the block to running at the next edge. `rts_n` is then 0 (hardware mode), and `xon_req` pulses for one cycle if `sw_fc_en`=1.
- R7: A fill count above resume×8 and below stop×8 leaves the state unchanged. A count one below stop×8 does not halt.
- R8: With both modes disabled, the block is forced to running at the next edge and no XON or XOFF request is raised, even when it leaves the halted state.
- R9: With `hw_fc_en`=0, `rts_n` equals the inverse of `sw_rts` at all times. With `sw_fc_en`=0, no requests are raised while hardware mode still halts and resumes.
- R10: The ends of the range apply as written: a stop level of 0 halts at any fill count, and a stop level of 15 halts at 120 bytes but not at 119.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Threshold register write strobe |
| cfg_wdata | input | 8 | Write data: [3:0] stop level, [7:4] resume level |
| feat_en | input | 1 | Extended-features enable (write gate 1) |
| mctl_en | input | 1 | Modem-control enable (write gate 2) |
| hw_fc_en | input | 1 | Hardware (RTS) flow control enable |
| sw_fc_en | input | 1 | Software (XON/XOFF) flow control enable |
| sw_rts | input | 1 | Software RTS bit, 1 = assert (pin low), used when hardware mode is off |
| fill_cnt | input | 8 | Current receive FIFO fill count in bytes |
| cfg_q | output | 8 | Stored threshold register |
| rts_n | output | 1 | Active-low request to send |
| xoff_req | output | 1 | One-cycle request to send XOFF |
| xon_req | output | 1 | One-cycle request to send XON |

## Verification
The hardest situation to reach is a halted block that loses both enables. The block has to drop to running without an XON request, and this only shows up once hardware mode is turned back on with a fill count inside the hysteresis band, where a stale halted state would keep `rts_n` high. The stimulus first halts the block in software mode, then clears both enables, and then re-enables it at a mid-band fill count. A scoreboard queue holds the expected XON and XOFF pulses, so any pulse that was not expected is reported.

// File: rtl/fc_pkg.sv
package fc_pkg;
  localparam int LVL_W  = 4;
  localparam int CFG_W  = 2 * LVL_W;
  localparam int GRAN_SH = 3;

  typedef enum logic {
    FC_RUN  = 1'b0,
    FC_HALT = 1'b1
  } fc_state_e;

  typedef struct packed {
    logic [LVL_W-1:0] resume_lvl;
    logic [LVL_W-1:0] stop_lvl;
  } fc_cfg_t;
endpackage

// File: rtl/fc_thresh_reg.sv
module fc_thresh_reg
  import fc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CFG_W-1:0] wdata,
  input  logic             gate_a,
  input  logic             gate_b,
  output fc_cfg_t          cfg
);
  logic wr_ok;
  assign wr_ok = wr & gate_a & gate_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg <= '0;
    else if (wr_ok) cfg <= fc_cfg_t'(wdata);
  end

  AST_WR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && gate_a && gate_b) |=> (cfg == $past(wdata))); // R1
  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !(gate_a && gate_b)) |=> $stable(cfg)); // R2
endmodule

// File: rtl/fc_level_cmp.sv
module fc_level_cmp
  import fc_pkg::*;
#(
  parameter int FILL_W = 8
)(
  input  logic [FILL_W-1:0] fill,
  input  fc_cfg_t           cfg,
  output logic              at_stop,
  output logic              at_resume
);
  localparam int TH_W  = LVL_W + GRAN_SH;
  localparam int CMP_W = (FILL_W > TH_W) ? FILL_W : TH_W;

  logic [CMP_W-1:0] fill_x;
  logic [1:0]       hit;
  assign fill_x = CMP_W'(fill);

  // lane 0: stop (fill >= level*8), lane 1: resume (fill <= level*8)
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [LVL_W-1:0] lvl;
    logic [CMP_W-1:0] th;
    assign lvl = (g == 0) ? cfg.stop_lvl : cfg.resume_lvl;
    assign th  = CMP_W'({lvl, {GRAN_SH{1'b0}}});
    if (g == 0) begin : g_ge
      assign hit[g] = (fill_x >= th);
    end else begin : g_le
      assign hit[g] = (fill_x <= th);
    end
  end

  assign at_stop   = hit[0];
  assign at_resume = hit[1];
endmodule

// File: rtl/fc_hyst_fsm.sv
module fc_hyst_fsm
  import fc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hw_en,
  input  logic sw_en,
  input  logic sw_rts,
  input  logic at_stop,
  input  logic at_resume,
  output logic rts_n,
  output logic xoff_req,
  output logic xon_req
);
  fc_state_e st;
  logic      active;
  assign active = hw_en | sw_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= FC_RUN;
      xoff_req <= 1'b0;
      xon_req  <= 1'b0;
    end else begin
      xoff_req <= 1'b0;
      xon_req  <= 1'b0;
      if (!active) begin
        st <= FC_RUN;
      end else begin
        unique case (st)
          FC_RUN: if (at_stop) begin
            st       <= FC_HALT;
            xoff_req <= sw_en;
          end
          FC_HALT: if (at_resume) begin
            st      <= FC_RUN;
            xon_req <= sw_en;
          end
          default: st <= FC_RUN;
        endcase
      end
    end
  end

  assign rts_n = hw_en ? (st == FC_HALT) : ~sw_rts;

  AST_HALT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (active && st == FC_RUN && at_stop) |=> (st == FC_HALT)); // R4
  AST_XOFF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_req |=> !xoff_req); // R5
  AST_RESUME_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (active && st == FC_HALT && at_resume) |=> (st == FC_RUN)); // R6
  AST_FORCE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (st == FC_RUN && !xon_req)); // R8
  AST_SW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_en |=> (!xoff_req && !xon_req)); // R9
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(xoff_req && xon_req)); // R5
endmodule

// File: rtl/rx_flow_hyst.sv
module rx_flow_hyst
  import fc_pkg::*;
#(
  parameter int FILL_W = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [7:0]        cfg_wdata,
  input  logic              feat_en,
  input  logic              mctl_en,
  input  logic              hw_fc_en,
  input  logic              sw_fc_en,
  input  logic              sw_rts,
  input  logic [FILL_W-1:0] fill_cnt,
  output logic [7:0]        cfg_q,
  output logic              rts_n,
  output logic              xoff_req,
  output logic              xon_req
);
  fc_cfg_t cfg;
  logic    at_stop, at_resume;

  fc_thresh_reg i_reg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
    .gate_a(feat_en), .gate_b(mctl_en), .cfg(cfg)
  );

  fc_level_cmp #(.FILL_W(FILL_W)) i_cmp (
    .fill(fill_cnt), .cfg(cfg), .at_stop(at_stop), .at_resume(at_resume)
  );

  fc_hyst_fsm i_fsm (
    .clk(clk), .rst_n(rst_n), .hw_en(hw_fc_en), .sw_en(sw_fc_en),
    .sw_rts(sw_rts), .at_stop(at_stop), .at_resume(at_resume),
    .rts_n(rts_n), .xoff_req(xoff_req), .xon_req(xon_req)
  );

  assign cfg_q = cfg;

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (cfg_q == 8'h00 || rst_n)); // R3
endmodule

// File: tb/test_rx_flow_hyst.sv
module test_rx_flow_hyst;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic       feat_en = 1'b0, mctl_en = 1'b0;
  logic       hw_fc_en = 1'b0, sw_fc_en = 1'b0, sw_rts = 1'b1;
  logic [7:0] fill_cnt = '0;
  logic [7:0] cfg_q;
  logic       rts_n, xoff_req, xon_req;

  int checks = 0;
  int fails = 0;
  string exp_q[$];

  always #10 clk = ~clk; // 50 MHz

  rx_flow_hyst i_rx_flow_hyst (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .feat_en(feat_en), .mctl_en(mctl_en), .hw_fc_en(hw_fc_en),
    .sw_fc_en(sw_fc_en), .sw_rts(sw_rts), .fill_cnt(fill_cnt),
    .cfg_q(cfg_q), .rts_n(rts_n), .xoff_req(xoff_req), .xon_req(xon_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  // monitor: pops expected request pulses
  always @(negedge clk) begin
    if (rst_n && (xoff_req || xon_req)) begin
      string got;
      got = xoff_req ? "XOFF" : "XON";
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R5/R6/R8/R9 unexpected %s actual=%s expected=none", got, got);
      end else begin
        string e;
        e = exp_q.pop_front();
        if (e != got) begin
          fails++;
          $display("FAIL R5/R6 pulse actual=%s expected=%s", got, e);
        end
      end
    end
  end

  // driver: apply a value after an edge, then wait until the result is visible
  task automatic set_fill(input int v, input string evt);
    if (evt != "") exp_q.push_back(evt);
    @(posedge clk); #2;
    fill_cnt = 8'(v);
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [7:0] d, input logic a, input logic b);
    @(posedge clk); #2;
    cfg_wdata = d; feat_en = a; mctl_en = b; cfg_wr = 1'b1;
    @(posedge clk); #2;
    cfg_wr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R3
    chk("R3 cfg_q", cfg_q, 0);
    chk("R3 xoff_req", xoff_req, 0);
    chk("R3 xon_req", xon_req, 0);
    chk("R9 rts_n follows sw_rts", rts_n, 0);

    // R2
    wr_cfg(8'h3A, 1'b1, 1'b0);
    chk("R2 mctl_en low", cfg_q, 0);
    wr_cfg(8'h3A, 1'b0, 1'b1);
    chk("R2 feat_en low", cfg_q, 0);
    // R1
    wr_cfg(8'h26, 1'b1, 1'b1);
    chk("R1 write taken", cfg_q, 8'h26);

    // stop 6 (48 bytes), resume 2 (16 bytes)
    hw_fc_en = 1'b1; sw_fc_en = 1'b1;
    set_fill(47, "");
    chk("R7 below stop", rts_n, 0);
    set_fill(48, "XOFF");
    chk("R4 halted rts_n", rts_n, 1);
    set_fill(30, "");
    chk("R7 band keeps halt", rts_n, 1);
    set_fill(17, "");
    chk("R7 just above resume", rts_n, 1);
    set_fill(16, "XON");
    chk("R6 resumed rts_n", rts_n, 0);

    // R9: hardware only
    sw_fc_en = 1'b0;
    set_fill(60, "");
    chk("R9 hw halts silently", rts_n, 1);
    set_fill(0, "");
    chk("R9 hw resumes silently", rts_n, 0);

    // R9: software only, rts_n from sw_rts
    hw_fc_en = 1'b0; sw_fc_en = 1'b1;
    sw_rts = 1'b0; #1;
    chk("R9 sw_rts=0", rts_n, 1);
    sw_rts = 1'b1; #1;
    chk("R9 sw_rts=1", rts_n, 0);
    set_fill(50, "XOFF");
    chk("R9 rts_n ignores state", rts_n, 0);

    // R8: drop both enables while halted
    @(posedge clk); #2;
    sw_fc_en = 1'b0;
    fill_cnt = 8'd20;
    repeat (3) @(posedge clk);
    #2 hw_fc_en = 1'b1;
    @(negedge clk);
    chk("R8 forced to running", rts_n, 0);
    sw_fc_en = 1'b1;
    set_fill(20, "");
    chk("R8 stays running mid band", rts_n, 0);

    // R10 upper end: stop 15 (120), resume 14 (112)
    set_fill(0, "");
    wr_cfg(8'hEF, 1'b1, 1'b1);
    chk("R1 second write", cfg_q, 8'hEF);
    set_fill(119, "");
    chk("R10 119 no halt", rts_n, 0);
    set_fill(120, "XOFF");
    chk("R10 120 halts", rts_n, 1);
    set_fill(113, "");
    chk("R7 113 stays halted", rts_n, 1);
    set_fill(112, "XON");
    chk("R6 112 resumes", rts_n, 0);

    // R10 lower end: stop 0 halts at any fill, resume 0
    set_fill(5, "");
    exp_q.push_back("XOFF");
    wr_cfg(8'h00, 1'b1, 1'b1);
    @(negedge clk);
    chk("R10 stop 0 halts", rts_n, 1);
    set_fill(0, "XON");
    chk("R6 resume at 0", rts_n, 0);

    hw_fc_en = 1'b0; sw_fc_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R5 all expected pulses seen", exp_q.size(), 0);
    summary();
  end
endmodule